// File: doc/BRIEF.md
# Cache Access-Rate Gauge and Miss-Queue Throttle

This block watches the stream of last-level-cache accesses and keeps a running estimate of the average number of cycles between them. Each access adds the time since the previous access to a leaky gauge and takes the current rate estimate back out of it. When the gauge runs over its ceiling the rate estimate steps up by one; when it runs under zero the estimate steps down by one. The rate is therefore an 8-bit average interval that moves by at most one step per access.

From that rate and the most recent prefetch accuracy score, the block produces an occupancy limit for the miss-handling queue. Prefetches may be sent into the second-level cache only while the queue holds fewer entries than this limit. A good score, or a long interval between accesses, opens the limit fully. A very short interval closes it to the floor of 2. Between those two regions the limit rises linearly with the interval. A mode input raises the bandwidth constant from 16 to 64 for systems with little memory bandwidth.

The time input is a free-running cycle count, of which only the low 12 bits are used. The queue size is a parameter. The limit is held in a register and is only recomputed when the rate steps or when a new score arrives.

Top module: `llc_rate_throttle`

## Requirements
- R1: On each access the interval is (now − last) modulo 4096, where now is the low 12 bits of the cycle input, and last is then set to now. This wrap-around lets an access whose time stamp is numerically smaller than the previous one still yield a positive interval.
- R2: On each access the gauge changes by (interval − rate). Without an access, the gauge, the rate and the last time stamp hold their values.
- R3: If the updated gauge exceeds 8191, the gauge becomes 8191 and the rate rises by 1, but never above 255. The new rate appears on the rate output in the cycle after the access edge.
- R4: If the updated gauge is below 0, the gauge becomes 0 and the rate falls by 1, but never below 0.
- R5: If the score is above 20, or the rate is above twice the bandwidth constant, the limit is the queue size minus 4.
- R6: Otherwise, if the rate is below the bandwidth constant, the limit is 2.
- R7: In every other case the limit is 2 + (queue size − 6) × (rate − BW) / BW, with the division truncated to an integer.
- R8: The bandwidth constant BW is 16 while the low-bandwidth input is 0, and 64 while it is 1.
- R9: The limit is recomputed only on an edge where the rate changes or a score strobe arrives. The recomputation uses the updated rate and, on a score strobe, the new score. At any other time the limit holds, even if the low-bandwidth input changes.
- R10: After reset the rate is 0, the gauge is 0, the stored score is 0, the last time stamp is 0 and the limit is the queue size minus 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cycle_now | input | 12 | Low bits of the free-running cycle count |
| access_i | input | 1 | One cache access this cycle |
| score_valid_i | input | 1 | New prefetch score delivered this cycle |
| score_i | input | 5 | Prefetch accuracy score |
| low_bw_i | input | 1 | Low-bandwidth mode select |
| rate_o | output | 8 | Average access-interval estimate |
| threshold_o | output | 4 | Miss-queue occupancy limit (queue size 16 by default) |

## Verification
The bench runs a time stamp backwards across the 4096 wrap point. A design that treats the interval as signed never pushes the gauge over its ceiling, so the rate stays at 0 where it should have reached 1. It drives the rate up to 255 and back down again. Along the way it checks the region edges: a rate equal to BW, a rate equal to 2×BW, and score 20 versus 21. An off-by-one comparison at any of these edges shifts the limit, and a missing saturation wraps the rate to 0. It also flips the low-bandwidth input without a strobe and with a strobe. A design that recomputes the limit all the time changes the limit too early, and one that recomputes from the old rate lags the limit by one step.

// File: rtl/llc_thr_pkg.sv
package llc_thr_pkg;

    localparam int TIME_W     = 12;
    localparam int RATE_W     = 8;
    localparam int SCORE_W    = 5;
    localparam int GAUGE_MAX  = 8191;
    localparam int RATE_MAX   = (1 << RATE_W) - 1;
    localparam int LOW_SCORE  = 20;
    localparam int THR_FLOOR  = 2;
    localparam int BW_SHIFT_N = 4;   // bandwidth constant 16
    localparam int BW_SHIFT_L = 6;   // bandwidth constant 64
    // signed width that holds gauge + largest interval, plus sign
    localparam int GAUGE_W    = $clog2(GAUGE_MAX + 1 + (1 << TIME_W)) + 1;

    typedef struct packed {
        logic signed [GAUGE_W-1:0] level;
        logic [RATE_W-1:0]         rate;
        logic [TIME_W-1:0]         stamp;
    } gauge_state_t;

    // occupancy limit for a given rate, score and mode
    function automatic int limit_for(input int rate, input int score,
                                     input logic low_bw, input int top_lim);
        int sh;
        int bw;
        sh = low_bw ? BW_SHIFT_L : BW_SHIFT_N;
        bw = 1 << sh;
        if ((score > LOW_SCORE) || (rate > 2 * bw))
            return top_lim;
        else if (rate < bw)
            return THR_FLOOR;
        else
            return THR_FLOOR + (((top_lim - THR_FLOOR) * (rate - bw)) >>> sh);
    endfunction

endpackage

// File: rtl/llc_interval_gauge.sv
module llc_interval_gauge
    import llc_thr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              access_i,
    input  logic [TIME_W-1:0] now_i,
    output logic [RATE_W-1:0] rate_o,
    output logic [RATE_W-1:0] rate_nxt_o,
    output logic              rate_step_o
);

    localparam logic signed [GAUGE_W-1:0] LEVEL_TOP = GAUGE_W'(GAUGE_MAX);

    gauge_state_t st_q, st_d;
    logic [TIME_W-1:0]         gap;
    logic signed [GAUGE_W-1:0] raw;

    always_comb begin
        gap = now_i - st_q.stamp;
        raw = st_q.level
            + $signed({{(GAUGE_W-TIME_W){1'b0}}, gap})
            - $signed({{(GAUGE_W-RATE_W){1'b0}}, st_q.rate});
        st_d = st_q;
        if (access_i) begin
            st_d.stamp = now_i;
            if (raw > LEVEL_TOP) begin
                st_d.level = LEVEL_TOP;
                if (st_q.rate != RATE_W'(RATE_MAX))
                    st_d.rate = st_q.rate + 1'b1;
            end else if (raw < 0) begin
                st_d.level = '0;
                if (st_q.rate != '0)
                    st_d.rate = st_q.rate - 1'b1;
            end else begin
                st_d.level = raw;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign rate_o      = st_q.rate;
    assign rate_nxt_o  = st_d.rate;
    assign rate_step_o = (st_d.rate != st_q.rate);

endmodule

// File: rtl/llc_mshr_limit.sv
module llc_mshr_limit
    import llc_thr_pkg::*;
#(
    parameter int MSHR_COUNT = 16,
    localparam int LIM_TOP   = MSHR_COUNT - 4,
    localparam int LIM_W     = $clog2(LIM_TOP + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [RATE_W-1:0]  rate_nxt_i,
    input  logic               rate_step_i,
    input  logic               score_valid_i,
    input  logic [SCORE_W-1:0] score_i,
    input  logic               low_bw_i,
    output logic [LIM_W-1:0]   limit_o
);

    logic [SCORE_W-1:0] score_q, score_use;
    logic [LIM_W-1:0]   limit_q, limit_calc;
    logic               refresh;

    always_comb begin
        score_use  = score_valid_i ? score_i : score_q;
        refresh    = rate_step_i | score_valid_i;
        limit_calc = LIM_W'(limit_for(int'(rate_nxt_i), int'(score_use),
                                      low_bw_i, LIM_TOP));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            score_q <= '0;
            limit_q <= LIM_W'(LIM_TOP);
        end else begin
            if (score_valid_i) score_q <= score_i;
            if (refresh)       limit_q <= limit_calc;
        end
    end

    assign limit_o = limit_q;

endmodule

// File: rtl/llc_rate_throttle.sv
module llc_rate_throttle
    import llc_thr_pkg::*;
#(
    parameter int MSHR_COUNT = 16
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic [TIME_W-1:0]                  cycle_now,
    input  logic                               access_i,
    input  logic                               score_valid_i,
    input  logic [SCORE_W-1:0]                 score_i,
    input  logic                               low_bw_i,
    output logic [RATE_W-1:0]                  rate_o,
    output logic [$clog2(MSHR_COUNT-3)-1:0]    threshold_o
);

    logic [RATE_W-1:0] rate_nxt;
    logic              rate_step;

    llc_interval_gauge u_gauge (
        .clk         (clk),
        .rst         (rst),
        .access_i    (access_i),
        .now_i       (cycle_now),
        .rate_o      (rate_o),
        .rate_nxt_o  (rate_nxt),
        .rate_step_o (rate_step)
    );

    llc_mshr_limit #(.MSHR_COUNT(MSHR_COUNT)) u_limit (
        .clk           (clk),
        .rst           (rst),
        .rate_nxt_i    (rate_nxt),
        .rate_step_i   (rate_step),
        .score_valid_i (score_valid_i),
        .score_i       (score_i),
        .low_bw_i      (low_bw_i),
        .limit_o       (threshold_o)
    );

endmodule

// File: rtl/llc_rate_throttle_chk.sv
module llc_rate_throttle_chk
    import llc_thr_pkg::*;
#(
    parameter int MSHR_COUNT = 16
) (
    input logic                            clk,
    input logic                            rst,
    input logic                            access_i,
    input logic                            score_valid_i,
    input logic [SCORE_W-1:0]              score_i,
    input logic [RATE_W-1:0]               rate_o,
    input logic [$clog2(MSHR_COUNT-3)-1:0] threshold_o
);

    localparam int TOP = MSHR_COUNT - 4;

    // R2: no access, no rate movement
    assert_rate_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !access_i |=> $stable(rate_o));

    // R3: at the ceiling the rate never wraps to a small value
    assert_rate_ceiling_R3: assert property (@(posedge clk) disable iff (rst)
        (access_i && rate_o == RATE_W'(RATE_MAX)) |=> (rate_o >= RATE_W'(RATE_MAX - 1)));

    // R4: at zero the rate never wraps to a large value
    assert_rate_floor_R4: assert property (@(posedge clk) disable iff (rst)
        (access_i && rate_o == '0) |=> (rate_o <= RATE_W'(1)));

    // R5: a high score opens the limit fully
    assert_good_score_R5: assert property (@(posedge clk) disable iff (rst)
        (score_valid_i && score_i > SCORE_W'(LOW_SCORE)) |=> (int'(threshold_o) == TOP));

    // R7: the limit always lies between the floor and the top
    assert_limit_range_R7: assert property (@(posedge clk) disable iff (rst)
        (int'(threshold_o) >= THR_FLOOR) && (int'(threshold_o) <= TOP));

    // R9: with no event the limit holds
    assert_limit_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!access_i && !score_valid_i) |=> $stable(threshold_o));

endmodule

bind llc_rate_throttle llc_rate_throttle_chk #(.MSHR_COUNT(MSHR_COUNT)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .access_i      (access_i),
    .score_valid_i (score_valid_i),
    .score_i       (score_i),
    .rate_o        (rate_o),
    .threshold_o   (threshold_o)
);

// File: tb/llc_rate_throttle_tb.sv
module llc_rate_throttle_tb;

    localparam int MSHR = 16;
    localparam int TOPL = MSHR - 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] cycle_now = '0;
    logic        access_i = 1'b0;
    logic        score_valid_i = 1'b0;
    logic [4:0]  score_i = '0;
    logic        low_bw_i = 1'b0;
    logic [7:0]  rate_o;
    logic [3:0]  threshold_o;

    int checks = 0;
    int errors = 0;

    // reference state
    int m_gauge, m_rate, m_last, m_score, m_thr;
    logic m_lbw;

    always #2.5 clk = ~clk;

    llc_rate_throttle #(.MSHR_COUNT(MSHR)) u_dut (
        .clk(clk), .rst(rst), .cycle_now(cycle_now), .access_i(access_i),
        .score_valid_i(score_valid_i), .score_i(score_i), .low_bw_i(low_bw_i),
        .rate_o(rate_o), .threshold_o(threshold_o)
    );

    function automatic int exp_limit(int rate, int score, logic lbw);
        int bw;
        bw = lbw ? 64 : 16;
        if (score > 20 || rate > 2 * bw) return TOPL;
        if (rate < bw) return 2;
        return 2 + ((TOPL - 2) * (rate - bw)) / bw;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one clock with optional access and score strobe, then compare outputs
    task automatic step(bit acc, int t, bit sv, int sc, string req);
        bit chg;
        int dt, g;
        @(negedge clk);
        access_i      = acc;
        cycle_now     = 12'(t);
        score_valid_i = sv;
        score_i       = 5'(sc);
        low_bw_i      = m_lbw;
        chg = 0;
        if (acc) begin
            dt = (t - m_last) & 4095;
            m_last = t & 4095;
            g = m_gauge + dt - m_rate;
            if (g > 8191) begin
                g = 8191;
                if (m_rate < 255) begin m_rate++; chg = 1; end
            end else if (g < 0) begin
                g = 0;
                if (m_rate > 0) begin m_rate--; chg = 1; end
            end
            m_gauge = g;
        end
        if (sv) m_score = sc;
        if (chg || sv) m_thr = exp_limit(m_rate, m_score, m_lbw);
        @(negedge clk);
        access_i = 0;
        score_valid_i = 0;
        check({req, " rate"}, int'(rate_o), m_rate);
        check({req, " limit"}, int'(threshold_o), m_thr);
    endtask

    task automatic t_reset;   // R10
        @(negedge clk);
        rst = 1'b1;
        access_i = 0; score_valid_i = 0; m_lbw = 0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_gauge = 0; m_rate = 0; m_last = 0; m_score = 0; m_thr = TOPL;
        check("R10 reset rate", int'(rate_o), 0);
        check("R10 reset limit", int'(threshold_o), TOPL);
    endtask

    task automatic t_scores;  // R5 R6
        step(0, 0, 1, 21, "R5 score 21");
        check("R5 score 21 top", int'(threshold_o), TOPL);
        step(0, 0, 1, 20, "R6 score 20 low rate");
        check("R6 floor", int'(threshold_o), 2);
    endtask

    task automatic t_wrap;    // R1 R2
        t_reset();
        step(1, 4000, 0, 0, "R2 first gap");
        check("R2 no step yet", int'(rate_o), 0);
        step(0, 50, 0, 0, "R2 idle");
        step(1, 10, 0, 0, "R1 wrapped gap");     // gap 106, gauge 4106
        step(1, 9, 0, 0, "R1 wrapped max gap");  // gap 4095, gauge 8201 -> rate 1
        check("R1 wrap stepped rate", int'(rate_o), 1);
    endtask

    task automatic t_climb;   // R3 R7 R8
        int t;
        t_reset();
        step(0, 0, 1, 10, "R6 set low score");
        t = 0;
        for (int i = 0; i < 270; i++) begin
            t = (t + 4095) & 4095;
            step(1, t, 0, 0, "R3 climb");
            if (m_rate == 16) check("R7 rate=BW", int'(threshold_o), 2);
            if (m_rate == 20) check("R7 rate 20", int'(threshold_o), 4);
            if (m_rate == 32) check("R7 rate=2BW", int'(threshold_o), TOPL);
            if (m_rate == 33) check("R5 rate>2BW", int'(threshold_o), TOPL);
        end
        check("R3 saturated", int'(rate_o), 255);
    endtask

    task automatic t_mode_and_decay;  // R4 R8 R9
        int t;
        t = m_last;
        m_lbw = 1;
        step(0, t, 0, 0, "R9 mode flip no event");
        check("R9 limit held", int'(threshold_o), TOPL);
        for (int i = 0; i < 400; i++) begin
            step(1, t, 0, 0, "R4 decay");
            if (m_rate == 100) check("R8 low-bw rate 100", int'(threshold_o), 7);
            if (m_rate == 70)  check("R8 low-bw rate 70", int'(threshold_o), 2);
        end
        check("R4 floor rate", int'(rate_o), 0);
        m_lbw = 0;
        step(0, t, 1, 10, "R8 normal bw strobe");
    endtask

    task automatic t_mode_strobe;     // R8 R9
        int t;
        t_reset();
        t = 0;
        for (int i = 0; i < 42; i++) begin
            t = (t + 4095) & 4095;
            step(1, t, 0, 0, "R3 climb to 40");
        end
        check("R3 rate 40", int'(rate_o), 40);
        step(0, t, 1, 5, "R5 normal rate>2BW");
        check("R5 top", int'(threshold_o), TOPL);
        m_lbw = 1;
        step(0, t, 0, 0, "R9 hold after flip");
        check("R9 still top", int'(threshold_o), TOPL);
        step(0, t, 1, 5, "R8 low-bw strobe");
        check("R8 rate 40 under BW 64", int'(threshold_o), 2);
        m_lbw = 0;
    endtask

    initial begin
        #(5ns * 150000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        m_lbw = 0;
        t_reset();
        t_scores();
        t_wrap();
        t_climb();
        t_mode_and_decay();
        t_mode_strobe();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule